// File: doc/BRIEF.md
# Glitchless Clock Stop Controller

This block takes one of two source clocks and drives it onto three gated outputs: a fast clock for the logic array and a left and a right edge clock. One static configuration bit picks the source: the pad clock at the middle of the side, or the clock routed in from the corner. A shutoff input, whose active level is set by configuration, parks all three outputs at a fixed level and later releases them. No output ever shows a runt pulse or a shortened phase.

A second configuration bit picks the stop edge. In rising-edge mode the shutoff request is sampled on rising source edges and the outputs park high. In falling-edge mode it is sampled on falling edges and the outputs park low. The request passes through one sampling flop and then into a two-state machine. Its states are `ST_RUN` (outputs follow the source) and `ST_PARKED` (outputs held at the parked level). It has two transitions. **RUN→PARKED** is taken on a stop edge when the sampled request is active. **PARKED→RUN** is taken on a stop edge when the sampled request is inactive. The state register changes only on the stop edge, and at that moment the source clock already sits at the parked level, so gating never cuts a phase. A status output reports the parked state.

Top module: `clkstop_ctrl`

## Requirements
- R1: `cfg_src_corner`=0 selects `pad_clk_i` as the source; `cfg_src_corner`=1 selects `corner_clk_i`. While running, every output follows the selected source.
- R2: The three gated outputs carry the same level at all times.
- R3: With `cfg_shut_inv`=0 the shutoff input is active-high. With `cfg_shut_inv`=1 it is active-low, and a held high level leaves the outputs running.
- R4: With `cfg_stop_rise`=1 the stop edge is the rising source edge, and parked outputs sit at logic 1.
- R5: With `cfg_stop_rise`=0 the stop edge is the falling source edge, and parked outputs sit at logic 0.
- R6: A request that becomes active ahead of stop edge k is sampled at k. The outputs still run until edge k+1 and make no transition after edge k+1.
- R7: A request that becomes inactive ahead of stop edge m leaves the outputs parked through m. They resume at edge m+1, and their first phase after that is a full source phase.
- R8: No high or low phase on the outputs is shorter than half a source period, through any stop or restart.
- R9: While `rst_n` is low, and after it rises, the block is in the running state with `parked_o`=0.
- R10: `parked_o` rises on the stop edge that completes a stop (k+1) and falls on the stop edge that completes a restart (m+1). A one-stop-edge pulse on shutoff parks the outputs for exactly one source cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pad_clk_i | input | 1 | Mid-side pad source clock |
| corner_clk_i | input | 1 | Corner-routed source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_src_corner | input | 1 | Static source select (1 = corner clock) |
| cfg_stop_rise | input | 1 | Stop edge select (1 = rising edge, park high) |
| cfg_shut_inv | input | 1 | Shutoff polarity (1 = active low) |
| shutoff_i | input | 1 | Clock shutoff request |
| fast_clk_o | output | 1 | Gated fast array clock |
| edge_left_clk_o | output | 1 | Gated left edge clock |
| edge_right_clk_o | output | 1 | Gated right edge clock |
| parked_o | output | 1 | High while the gated outputs are parked |

## Verification
Completing a stop and receiving a restart request can land on the same stop edge. This happens when shutoff is pulsed for exactly one stop-edge period: the state machine enters `ST_PARKED` on the same edge at which the sampling flop already sees the request withdrawn. The bench provokes this by driving the pulse between opposite edges, in both stop modes. It judges the result by `parked_o` staying high for exactly one cycle, by the output staying at the parked level across that cycle, and by a pulse-width monitor that finds no phase shorter than half a period.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Number of gated clock outputs driven from the one source.
    localparam int unsigned NUM_GATED = 3;

    // Index of each gated output in the gate vector.
    localparam int unsigned IDX_FAST  = 0;
    localparam int unsigned IDX_LEFT  = 1;
    localparam int unsigned IDX_RIGHT = 2;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_PARKED = 1'b1
    } park_state_e;

endpackage

// File: rtl/clkstop_src_mux.sv
module clkstop_src_mux (
    input  logic pad_clk,
    input  logic corner_clk,
    input  logic sel_corner,
    output logic src_clk
);

    // The select is static configuration, so a plain mux is enough here.
    always_comb begin
        src_clk = sel_corner ? corner_clk : pad_clk;
    end

endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int unsigned STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req_s,
    output logic parked
);

    park_state_e state_q;
    park_state_e state_d;

    // State register: the last synchronizer stage in the request path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (stop_req_s)  state_d = ST_PARKED;
            ST_PARKED: if (!stop_req_s) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_PARKED: parked = 1'b1;
            default:   parked = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int unsigned N = 3
) (
    input  logic         src_clk,
    input  logic         parked,
    input  logic         park_level,
    output logic [N-1:0] gclk
);

    // parked only changes right after a stop edge, when src_clk already
    // equals park_level, so each mux output never changes at that moment.
    generate
        for (genvar i = 0; i < N; i++) begin : g_out
            assign gclk[i] = parked ? park_level : src_clk;
        end
    endgenerate

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned SAMPLE_STAGES = 1
) (
    input  logic pad_clk_i,
    input  logic corner_clk_i,
    input  logic rst_n,
    input  logic cfg_src_corner,
    input  logic cfg_stop_rise,
    input  logic cfg_shut_inv,
    input  logic shutoff_i,
    output logic fast_clk_o,
    output logic edge_left_clk_o,
    output logic edge_right_clk_o,
    output logic parked_o
);

    logic                 src_clk;
    logic                 smp_clk;
    logic                 stop_req;
    logic                 stop_req_s;
    logic                 parked;
    logic [NUM_GATED-1:0] gclk;

    clkstop_src_mux u_mux (
        .pad_clk    (pad_clk_i),
        .corner_clk (corner_clk_i),
        .sel_corner (cfg_src_corner),
        .src_clk    (src_clk)
    );

    // The rising edge of smp_clk is the selected stop edge of the source.
    assign smp_clk  = src_clk ^ ~cfg_stop_rise;
    assign stop_req = shutoff_i ^ cfg_shut_inv;

    clkstop_sync #(.STAGES(SAMPLE_STAGES)) u_sync (
        .clk   (smp_clk),
        .rst_n (rst_n),
        .d     (stop_req),
        .q     (stop_req_s)
    );

    clkstop_fsm u_fsm (
        .clk        (smp_clk),
        .rst_n      (rst_n),
        .stop_req_s (stop_req_s),
        .parked     (parked)
    );

    clkstop_gate #(.N(NUM_GATED)) u_gate (
        .src_clk    (src_clk),
        .parked     (parked),
        .park_level (cfg_stop_rise),
        .gclk       (gclk)
    );

    assign fast_clk_o       = gclk[IDX_FAST];
    assign edge_left_clk_o  = gclk[IDX_LEFT];
    assign edge_right_clk_o = gclk[IDX_RIGHT];
    assign parked_o         = parked;

endmodule

// File: rtl/clkstop_checker.sv
module clkstop_checker (
    input logic smp_clk,
    input logic rst_n,
    input logic cfg_stop_rise,
    input logic stop_req,
    input logic fast_clk_o,
    input logic edge_left_clk_o,
    input logic edge_right_clk_o,
    input logic parked_o
);

    logic [1:0] since_rst;

    always_ff @(posedge smp_clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_outs_match_r2: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (fast_clk_o == edge_left_clk_o) && (fast_clk_o == edge_right_clk_o));

    // Covers R5 as well: the parked level follows the stop-edge mode.
    p_park_level_r4: assert property (@(posedge smp_clk) disable iff (!rst_n)
        parked_o |-> (fast_clk_o == cfg_stop_rise));

    p_stop_latency_r6: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && stop_req && $past(stop_req)) |=> parked_o);

    p_restart_latency_r7: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !stop_req && !$past(stop_req)) |=> !parked_o);

endmodule

bind clkstop_ctrl clkstop_checker u_chk (
    .smp_clk          (smp_clk),
    .rst_n            (rst_n),
    .cfg_stop_rise    (cfg_stop_rise),
    .stop_req         (stop_req),
    .fast_clk_o       (fast_clk_o),
    .edge_left_clk_o  (edge_left_clk_o),
    .edge_right_clk_o (edge_right_clk_o),
    .parked_o         (parked_o)
);

// File: tb/tb_clkstop_ctrl.sv
module tb_clkstop_ctrl;

    localparam int CLK_PERIOD    = 10;
    localparam int CORNER_PERIOD = 14;

    logic pad_clk = 1'b0;
    logic corner_clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_src_corner = 1'b0;
    logic cfg_stop_rise = 1'b1;
    logic cfg_shut_inv = 1'b0;
    logic shutoff_i = 1'b0;
    logic fast_clk_o, edge_left_clk_o, edge_right_clk_o, parked_o;

    int n_checks = 0;
    int n_fail = 0;
    int tog_cnt = 0;
    int runt_cnt = 0;
    bit mon_en = 1'b0;
    time last_t = 0;

    always #(CLK_PERIOD/2) pad_clk = ~pad_clk;
    always #(CORNER_PERIOD/2) corner_clk = ~corner_clk;

    clkstop_ctrl dut (
        .pad_clk_i        (pad_clk),
        .corner_clk_i     (corner_clk),
        .rst_n            (rst_n),
        .cfg_src_corner   (cfg_src_corner),
        .cfg_stop_rise    (cfg_stop_rise),
        .cfg_shut_inv     (cfg_shut_inv),
        .shutoff_i        (shutoff_i),
        .fast_clk_o       (fast_clk_o),
        .edge_left_clk_o  (edge_left_clk_o),
        .edge_right_clk_o (edge_right_clk_o),
        .parked_o         (parked_o)
    );

    wire src_ref = cfg_src_corner ? corner_clk : pad_clk;

    // Phase-width monitor for R8 and a transition counter.
    always @(fast_clk_o) begin
        if (mon_en) begin
            tog_cnt++;
            if (($time - last_t) < time'((cfg_src_corner ? CORNER_PERIOD : CLK_PERIOD) / 2))
                runt_cnt++;
        end
        last_t = $time;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic stop_edge();
        if (cfg_stop_rise) @(posedge src_ref);
        else               @(negedge src_ref);
    endtask

    task automatic opp_edge();
        if (cfg_stop_rise) @(negedge src_ref);
        else               @(posedge src_ref);
    endtask

    task automatic outs_same(input string req);
        chk(fast_clk_o == edge_left_clk_o && fast_clk_o == edge_right_clk_o, req,
            {fast_clk_o, edge_left_clk_o, edge_right_clk_o}, {3{fast_clk_o}});
    endtask

    // Reset with a configuration; R9 checked during and after reset.
    task automatic t_reset(input bit corner, input bit rise, input bit inv);
        mon_en = 1'b0;
        rst_n = 1'b0;
        cfg_src_corner = corner;
        cfg_stop_rise = rise;
        cfg_shut_inv = inv;
        shutoff_i = inv;
        #(CLK_PERIOD*2 + 1);
        chk(parked_o == 1'b0, "R9 in reset", parked_o, 0);
        rst_n = 1'b1;
        repeat (3) stop_edge();
        #1;
        chk(parked_o == 1'b0, "R9 after reset", parked_o, 0);
        runt_cnt = 0;
        mon_en = 1'b1;
    endtask

    task automatic t_source(input bit corner);
        t_reset(corner, 1'b1, 1'b0);
        repeat (4) begin
            @(posedge (corner ? corner_clk : pad_clk)); #1;
            chk(fast_clk_o == 1'b1, "R1 high phase", fast_clk_o, 1);
            outs_same("R2 high phase");
            @(negedge (corner ? corner_clk : pad_clk)); #1;
            chk(fast_clk_o == 1'b0, "R1 low phase", fast_clk_o, 0);
            outs_same("R2 low phase");
        end
    endtask

    // Full stop then restart; R4/R5 level, R6/R7 latency, R8, R10.
    task automatic t_stop_start(input bit corner, input bit rise, input bit inv);
        t_reset(corner, rise, inv);
        opp_edge(); #1;
        shutoff_i = ~inv;
        stop_edge(); #1; // edge k
        chk(parked_o == 1'b0, "R6 still running at k", parked_o, 0);
        opp_edge(); #1;
        chk(fast_clk_o == !rise, "R6 toggles between k and k+1", fast_clk_o, !rise);
        stop_edge(); #1; // edge k+1
        chk(parked_o == 1'b1, "R10 parked at k+1", parked_o, 1);
        tog_cnt = 0;
        repeat (5) stop_edge();
        #1;
        chk(tog_cnt == 0, "R6 no transition once parked", tog_cnt, 0);
        if (rise) chk(fast_clk_o == 1'b1, "R4 park high", fast_clk_o, 1);
        else      chk(fast_clk_o == 1'b0, "R5 park low", fast_clk_o, 0);
        outs_same("R2 parked");
        opp_edge(); #1;
        shutoff_i = inv;
        stop_edge(); #1; // edge m
        chk(parked_o == 1'b1, "R7 parked through m", parked_o, 1);
        stop_edge(); #1; // edge m+1
        chk(parked_o == 1'b0, "R10 run at m+1", parked_o, 0);
        opp_edge(); #1;
        chk(fast_clk_o == !rise, "R7 resumes", fast_clk_o, !rise);
        repeat (2) stop_edge();
        chk(runt_cnt == 0, "R8 no runt", runt_cnt, 0);
    endtask

    // R3: inverted polarity, held high keeps running.
    task automatic t_inverted_idle();
        t_reset(1'b0, 1'b1, 1'b1);
        tog_cnt = 0;
        repeat (6) stop_edge();
        #1;
        chk(parked_o == 1'b0, "R3 high level ignored when inverted", parked_o, 0);
        chk(tog_cnt >= 10, "R3 outputs keep toggling", tog_cnt, 10);
    endtask

    // One-edge shutoff pulse: stop completes as restart arrives (R10, R8).
    task automatic t_pulse(input bit rise);
        t_reset(1'b0, rise, 1'b0);
        opp_edge(); #1;
        shutoff_i = 1'b1;
        stop_edge();       // k
        opp_edge(); #1;
        shutoff_i = 1'b0;
        stop_edge(); #1;   // k+1
        chk(parked_o == 1'b1, "R10 pulse parks", parked_o, 1);
        opp_edge(); #1;
        chk(fast_clk_o == rise, "R10 held across pulse", fast_clk_o, rise);
        stop_edge(); #1;   // k+2
        chk(parked_o == 1'b0, "R10 pulse one cycle", parked_o, 0);
        repeat (2) stop_edge();
        chk(runt_cnt == 0, "R8 no runt on pulse", runt_cnt, 0);
    endtask

    initial begin
        t_source(1'b0);
        t_source(1'b1);
        t_stop_start(1'b0, 1'b1, 1'b0);
        t_stop_start(1'b0, 1'b0, 1'b0);
        t_stop_start(1'b1, 1'b1, 1'b1);
        t_stop_start(1'b1, 1'b0, 1'b1);
        t_inverted_idle();
        t_pulse(1'b1);
        t_pulse(1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule